// File: doc/BRIEF.md
# Network Interrupt Status Aggregator

This block gathers interrupt requests from the network modules of a chassis into status words. Software can read those words, and the block drives one combined network interrupt line. Each request names a slot and a port. A set request raises the matching status bit and a clear request lowers it. Each slot owns four interrupt lines, numbered as ports 0 to 3.

A static `large_mode` input picks one of two layouts:

- **Four-slot layout** (`large_mode` = 0): slots 0 to 3 share word 0, and software reads that word one byte at a time.
- **Large layout** (`large_mode` = 1): slots 1 to 6 share word 0. Slot 0 has a separate word 1. Both words are read whole.

In both layouts the mapping from slot to bit position is deliberately non-linear. It must match what software decodes.

The read port is combinational over the registered status. The interrupt line is registered and changes on the same clock edge as the status bits that cause it.

Top module: `net_irq_aggr`

## Requirements
- R1: A valid set request sets status bit (base + port) of the word assigned to its slot. A valid clear request clears that same bit.
- R2: With `large_mode`=0, the base bits are 16 for slot 0, 24 for slot 1, 0 for slot 2 and 8 for slot 3, all in word 0.
- R3: With `large_mode`=0, the byte selects return word 0 bits 31:24 on select 0, bits 23:16 on select 1, bits 15:8 on select 2 and bits 7:0 on select 3, zero-extended to 32 bits.
- R4: With `large_mode`=1, slot 0 uses word 1 with base 0. Slots 1, 2, 3, 4, 5 and 6 use word 0 with bases 24, 16, 28, 20, 8 and 0.
- R5: Select 4 returns all of word 0 and select 5 returns all of word 1. Selects 6 and 7 return zero.
- R6: `irq_o` is high exactly when word 0 is nonzero, or, with `large_mode`=1, when word 1 is nonzero.
- R7: With `large_mode`=0, requests for slots 4 to 7 change no status bit, and word 1 stays zero. With `large_mode`=1, requests for slot 7 change nothing.
- R8: Requests with a port value of 4 to 7 change no status bit.
- R9: A set and a clear aimed at the same bit in one cycle leave the bit set. A set and a clear aimed at different bits in one cycle are both applied.
- R10: Reset clears both words and drives `irq_o` low.
- R11: A request takes effect on the next rising clock edge. `irq_o` reflects the new status from that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| large_mode | input | 1 | Static layout select: 0 four-slot, 1 large |
| set_vld | input | 1 | Set request strobe |
| set_slot | input | 3 | Slot of the set request |
| set_port | input | 3 | Port of the set request |
| clr_vld | input | 1 | Clear request strobe |
| clr_slot | input | 3 | Slot of the clear request |
| clr_port | input | 3 | Port of the clear request |
| rd_sel | input | 3 | Read register select |
| rd_data | output | 32 | Read data for `rd_sel` |
| irq_o | output | 1 | Combined network interrupt |

## Verification
In each layout, single requests go to every slot using different ports. These patterns separate the base of each slot and show whether the port offset is added. Accumulating those bits into one word, and then reading each byte select, shows whether the byte lanes are swapped.

Requests to slots that do not exist and to out-of-range ports are sent to an empty block. Any stray bit would show up in the words or on `irq_o`.

Same-cycle set and clear pairs are sent to one bit and to two different bits. These show the priority rule apart from the rule that concurrent requests are all applied. A pattern that uses only word 1 in the large layout shows whether that word feeds the interrupt.

// File: rtl/net_irq_aggr.sv
module net_irq_aggr #(
  parameter int WORD_W = 32,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              large_mode,
  input  logic              set_vld,
  input  logic [2:0]        set_slot,
  input  logic [2:0]        set_port,
  input  logic              clr_vld,
  input  logic [2:0]        clr_slot,
  input  logic [2:0]        clr_port,
  input  logic [2:0]        rd_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_o
);
  localparam int MW = 2 * WORD_W;

  logic [WORD_W-1:0] w0, w1;
  logic [MW-1:0]     smask, cmask;
  logic [WORD_W-1:0] nw0, nw1;

  function automatic logic [MW-1:0] bit_mask(input logic lg, input logic [2:0] s,
                                             input logic [2:0] p);
    logic [4:0] b;
    logic       hi;
    logic       ok;
    logic [5:0] idx;
    ok = 1'b1;
    hi = 1'b0;
    b  = 5'd0;
    if (!lg) begin
      case (s)
        3'd0: b = 5'd16;
        3'd1: b = 5'd24;
        3'd2: b = 5'd0;
        3'd3: b = 5'd8;
        default: ok = 1'b0;
      endcase
    end else begin
      case (s)
        3'd0: hi = 1'b1;
        3'd1: b = 5'd24;
        3'd2: b = 5'd16;
        3'd3: b = 5'd28;
        3'd4: b = 5'd20;
        3'd5: b = 5'd8;
        3'd6: b = 5'd0;
        default: ok = 1'b0;
      endcase
    end
    idx = {hi, b + {3'b000, p[1:0]}};
    bit_mask = '0;
    if (ok && (p < 3'(LINES)))
      bit_mask[idx] = 1'b1;
  endfunction

  assign smask = set_vld ? bit_mask(large_mode, set_slot, set_port) : '0;
  assign cmask = clr_vld ? bit_mask(large_mode, clr_slot, clr_port) : '0;

  assign nw0 = (w0 & ~cmask[WORD_W-1:0])  | smask[WORD_W-1:0];
  assign nw1 = (w1 & ~cmask[MW-1:WORD_W]) | smask[MW-1:WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w0    <= '0;
      w1    <= '0;
      irq_o <= 1'b0;
    end else begin
      w0    <= nw0;
      w1    <= nw1;
      irq_o <= (|nw0) | (large_mode & (|nw1));
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = {{(WORD_W-8){1'b0}}, w0[31:24]};
      3'd1:    rd_data = {{(WORD_W-8){1'b0}}, w0[23:16]};
      3'd2:    rd_data = {{(WORD_W-8){1'b0}}, w0[15:8]};
      3'd3:    rd_data = {{(WORD_W-8){1'b0}}, w0[7:0]};
      3'd4:    rd_data = w0;
      3'd5:    rd_data = w1;
      default: rd_data = '0;
    endcase
  end

  AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((|w0) || (large_mode && (|w1)))); // R6

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_vld |=> (({w1, w0} & $past(smask)) == $past(smask))); // R9

  AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vld |=> (({w1, w0} & $past(cmask & ~smask)) == '0)); // R1

  AST_FOUR_WORD1_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !large_mode |=> (w1 == '0)); // R7

  AST_BAD_PORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && set_port > 3'd3 && !clr_vld) |=> ($stable(w0) && $stable(w1))); // R8
endmodule

// File: tb/sim_net_irq_aggr.sv
`timescale 1ns/1ps
module sim_net_irq_aggr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        large_mode = 1'b0;
  logic        set_vld = 1'b0, clr_vld = 1'b0;
  logic [2:0]  set_slot = '0, set_port = '0, clr_slot = '0, clr_port = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq_o;
  int nvec = 0, nerr = 0;

  always #10 clk = ~clk;

  net_irq_aggr u0 (.clk, .rst_n, .large_mode, .set_vld, .set_slot, .set_port,
                   .clr_vld, .clr_slot, .clr_port, .rd_sel, .rd_data, .irq_o);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    large_mode = mode;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic req(input logic sv, input logic [2:0] ss, input logic [2:0] sp,
                     input logic cv, input logic [2:0] cs, input logic [2:0] cp);
    @(negedge clk);
    set_vld = sv; set_slot = ss; set_port = sp;
    clr_vld = cv; clr_slot = cs; clr_port = cp;
    @(negedge clk);
    set_vld = 1'b0;
    clr_vld = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset(1'b1);
    rd(3'd4, v); chk("R10 word0", v, 32'h0);
    rd(3'd5, v); chk("R10 word1", v, 32'h0);
    chk("R10 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_four_map();
    logic [31:0] v;
    do_reset(1'b0);
    req(1, 3'd0, 3'd0, 0, 3'd0, 3'd0);
    rd(3'd4, v); chk("R2 slot0 base", v, 32'h0001_0000);
    rd(3'd1, v); chk("R3 byte sel1", v, 32'h01);
    chk("R11 irq same edge", {31'b0, irq_o}, 32'h1);
    req(1, 3'd1, 3'd3, 0, 3'd0, 3'd0);
    req(1, 3'd2, 3'd1, 0, 3'd0, 3'd0);
    req(1, 3'd3, 3'd2, 0, 3'd0, 3'd0);
    rd(3'd4, v); chk("R2 all slots", v, 32'h0801_0402);
    rd(3'd0, v); chk("R3 byte sel0", v, 32'h08);
    rd(3'd2, v); chk("R3 byte sel2", v, 32'h04);
    rd(3'd3, v); chk("R3 byte sel3", v, 32'h02);
    req(0, 3'd0, 3'd0, 1, 3'd0, 3'd0);
    req(0, 3'd0, 3'd0, 1, 3'd1, 3'd3);
    req(0, 3'd0, 3'd0, 1, 3'd2, 3'd1);
    rd(3'd4, v); chk("R1 clear", v, 32'h0000_0400);
    chk("R6 irq still high", {31'b0, irq_o}, 32'h1);
    req(0, 3'd0, 3'd0, 1, 3'd3, 3'd2);
    chk("R6 irq low", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_four_ignore();
    logic [31:0] v;
    do_reset(1'b0);
    req(1, 3'd5, 3'd0, 0, 3'd0, 3'd0);
    req(1, 3'd4, 3'd3, 0, 3'd0, 3'd0);
    rd(3'd4, v); chk("R7 high slot word0", v, 32'h0);
    rd(3'd5, v); chk("R7 word1 idle", v, 32'h0);
    chk("R7 irq", {31'b0, irq_o}, 32'h0);
    req(1, 3'd0, 3'd4, 0, 3'd0, 3'd0);
    rd(3'd4, v); chk("R8 bad port four", v, 32'h0);
  endtask

  task automatic t_large();
    logic [31:0] v;
    do_reset(1'b1);
    req(1, 3'd0, 3'd2, 0, 3'd0, 3'd0);
    rd(3'd5, v); chk("R4 slot0 word1", v, 32'h4);
    rd(3'd4, v); chk("R4 slot0 not word0", v, 32'h0);
    chk("R6 irq from word1", {31'b0, irq_o}, 32'h1);
    req(0, 3'd0, 3'd0, 1, 3'd0, 3'd2);
    chk("R6 irq drop", {31'b0, irq_o}, 32'h0);
    req(1, 3'd1, 3'd0, 0, 3'd0, 3'd0);
    req(1, 3'd2, 3'd1, 0, 3'd0, 3'd0);
    req(1, 3'd3, 3'd2, 0, 3'd0, 3'd0);
    req(1, 3'd4, 3'd3, 0, 3'd0, 3'd0);
    req(1, 3'd5, 3'd0, 0, 3'd0, 3'd0);
    req(1, 3'd6, 3'd3, 0, 3'd0, 3'd0);
    req(1, 3'd7, 3'd1, 0, 3'd0, 3'd0);
    req(1, 3'd1, 3'd5, 0, 3'd0, 3'd0);
    rd(3'd4, v); chk("R4 slots1-6 (R7 R8 ignored)", v, 32'h4182_0108);
    rd(3'd5, v); chk("R5 word1 sel", v, 32'h0);
    rd(3'd6, v); chk("R5 sel6 zero", v, 32'h0);
    rd(3'd7, v); chk("R5 sel7 zero", v, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    do_reset(1'b1);
    req(1, 3'd6, 3'd1, 1, 3'd6, 3'd1);
    rd(3'd4, v); chk("R9 set wins", v, 32'h2);
    req(1, 3'd5, 3'd1, 1, 3'd6, 3'd1);
    rd(3'd4, v); chk("R9 both applied", v, 32'h200);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    t_reset();
    t_four_map();
    t_four_ignore();
    t_large();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule